// File: doc/BRIEF.md
# Accumulator Load/Store Sequencer with Pointer Indirection

This block carries out the single-word data moves of a small 16-bit two-accumulator machine. There are four moves: fill accumulator A from memory, fill accumulator B from memory, write A to memory, and write B to memory. A controller issues each one by pulsing `start` with an opcode, a 15-bit operand address and an indirect flag. The block then drives a synchronous word-addressed memory port, which has one cycle of read latency. When the move is complete it pulses `done`.

With the indirect flag clear, the operand address is used directly. With the flag set, the word at that address is read first, and its low 15 bits become the effective address. Normally only one level of indirection is taken. If `chain_en` is high when the move starts, bit 15 of each fetched pointer asks for one more level. A chain is bounded at eight pointer reads. A chain that would need a ninth read is abandoned: `err` is raised with `done`, and nothing is written.

Top module: `acc_xfer_unit`

## Requirements
- R1: Opcode 2'b00 loads the word at the effective address into accumulator A. Accumulator B is left unchanged.
- R2: Opcode 2'b01 loads the word at the effective address into accumulator B. Accumulator A is left unchanged.
- R3: Opcodes 2'b10 and 2'b11 write A and B respectively to the effective address. `mem_wr` is high for exactly one cycle, and `done` follows in the next cycle.
- R4: With `ind` set and `chain_en` clear, exactly one pointer word is read. Its low 15 bits are the effective address, and its bit 15 is ignored.
- R5: With `ind` and `chain_en` set, a fetched pointer with bit 15 set causes a further pointer read at its low 15 bits. A pointer with bit 15 clear ends the chain.
- R6: A chain of up to 8 pointer reads completes normally. If the 8th pointer still has bit 15 set, `err` and `done` pulse together 16 edges after the start edge, and neither memory nor accumulator is modified.
- R7: `done` is a one-cycle pulse. Counted in rising edges after the edge that samples `start`, it appears after 1 edge for a direct store and 2 for a direct load, plus 2 for every pointer read.
- R8: A `start` pulse that arrives while a move is in progress, including the cycle in which `done` is high, is ignored.
- R9: After reset, A and B are zero, and `done`, `err`, `mem_rd` and `mem_wr` are low.
- R10: An accumulator changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move (sampled when idle) |
| op | input | 2 | 00 load A, 01 load B, 10 store A, 11 store B |
| addr | input | 15 | Operand address |
| ind | input | 1 | Indirect flag |
| chain_en | input | 1 | Enable bit-15 chained indirection |
| done | output | 1 | Move complete pulse |
| err | output | 1 | Chain limit exceeded (with done) |
| reg_a | output | 16 | Accumulator A |
| reg_b | output | 16 | Accumulator B |
| mem_addr | output | 15 | Memory word address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |

## Verification
Completion of one move and the arrival of the next `start` can land in the same cycle. The bench provokes this by raising a store `start` in the very cycle where it observes `done` of a load. A second case raises a store `start` while a load is still fetching its operand. Each is judged correct if no extra `done` appears, the targeted memory words keep their old values, and the completed load has still delivered its data and latency exactly as predicted.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LDA = 2'b00,
    OP_LDB = 2'b01,
    OP_STA = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PTR,
    S_PWAIT,
    S_OPR,
    S_OWAIT,
    S_WRITE,
    S_DONE
  } seq_state_e;

  function automatic logic op_is_load(input lsu_op_e o);
    return !o[1];
  endfunction
endpackage

// File: rtl/lsu_hop_ctr.sv
module lsu_hop_ctr #(
  parameter int MAX_HOPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_HOPS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == LIMIT);
endmodule

// File: rtl/lsu_acc_regs.sv
module lsu_acc_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (we[g]) q[g] <= din;
    end
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ind,
  input  logic              chain_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic              hop_limit,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic              err,
  output logic [1:0]        acc_we,
  output logic              hop_clr,
  output logic              hop_inc
);
  seq_state_e state;
  lsu_op_e    op_q;
  lsu_op_e    op_in;
  logic       chain_q;
  logic       follow;

  assign op_in  = lsu_op_e'(op);
  assign follow = chain_q && mem_rdata[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_LDA;
      chain_q   <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          op_q     <= op_in;
          chain_q  <= chain_en;
          mem_addr <= addr;
          if (ind) begin
            state  <= S_PTR;
            mem_rd <= 1'b1;
          end else if (op_is_load(op_in)) begin
            state  <= S_OPR;
            mem_rd <= 1'b1;
          end else begin
            state     <= S_WRITE;
            mem_wr    <= 1'b1;
            mem_wdata <= (op_in == OP_STA) ? acc_a : acc_b;
          end
        end
        S_PTR:   state <= S_PWAIT;
        S_PWAIT: begin
          mem_addr <= mem_rdata[ADDR_W-1:0];
          if (follow) begin
            if (hop_limit) begin
              state <= S_DONE;
              done  <= 1'b1;
              err   <= 1'b1;
            end else begin
              state  <= S_PTR;
              mem_rd <= 1'b1;
            end
          end else if (op_is_load(op_q)) begin
            state  <= S_OPR;
            mem_rd <= 1'b1;
          end else begin
            state     <= S_WRITE;
            mem_wr    <= 1'b1;
            mem_wdata <= (op_q == OP_STA) ? acc_a : acc_b;
          end
        end
        S_OPR:   state <= S_OWAIT;
        S_OWAIT: begin
          state <= S_DONE;
          done  <= 1'b1;
        end
        S_WRITE: begin
          state <= S_DONE;
          done  <= 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // operand arrives in S_OWAIT; accumulator is written on the edge into S_DONE
  assign acc_we[0] = (state == S_OWAIT) && (op_q == OP_LDA);
  assign acc_we[1] = (state == S_OWAIT) && (op_q == OP_LDB);
  assign hop_clr   = (state == S_IDLE);
  assign hop_inc   = (state == S_PTR);
endmodule

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit #(
  parameter int DATA_W   = 16,
  parameter int MAX_HOPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-2:0] addr,
  input  logic              ind,
  input  logic              chain_en,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-2:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int NREG   = 2;

  logic [NREG-1:0]   acc_we;
  logic [DATA_W-1:0] acc_q [NREG];
  logic              hop_clr, hop_inc, hop_limit;

  lsu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .ind(ind),
    .chain_en(chain_en), .mem_rdata(mem_rdata), .acc_a(acc_q[0]), .acc_b(acc_q[1]),
    .hop_limit(hop_limit), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .done(done), .err(err), .acc_we(acc_we),
    .hop_clr(hop_clr), .hop_inc(hop_inc)
  );

  lsu_acc_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .we(acc_we), .din(mem_rdata), .q(acc_q)
  );

  lsu_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst(rst), .clr(hop_clr), .inc(hop_inc), .at_limit(hop_limit)
  );

  assign reg_a = acc_q[0];
  assign reg_b = acc_q[1];
endmodule

// File: rtl/acc_xfer_unit_chk.sv
module acc_xfer_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              err,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b
);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (rst) mem_wr |=> !mem_wr);
  p_wr_then_done_r3: assert property (@(posedge clk) disable iff (rst) mem_wr |=> done);
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst) err |-> done);
  p_err_no_write_r6: assert property (@(posedge clk) disable iff (rst) err |-> !$past(mem_wr));
  p_err_regs_kept_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(reg_a) && $stable(reg_b)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_acc_a_only_done_r10: assert property (@(posedge clk) disable iff (rst) !$stable(reg_a) |-> done);
  p_acc_b_only_done_r10: assert property (@(posedge clk) disable iff (rst) !$stable(reg_b) |-> done);
endmodule

bind acc_xfer_unit acc_xfer_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .err(err), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/tb_acc_xfer_unit.sv
`timescale 1ns/1ps
module tb_acc_xfer_unit;
  localparam logic [1:0] LDA = 2'b00, LDB = 2'b01, STA = 2'b10, STB = 2'b11;

  typedef struct {
    logic [15:0] a, b;
    logic        e;
    int          lat;
    int          chk_addr;
    logic [15:0] chk_val;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ind = 1'b0, chain_en = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [14:0] addr = '0;
  logic done, err, mem_rd, mem_wr;
  logic [15:0] reg_a, reg_b, mem_wdata, mem_rdata;
  logic [14:0] mem_addr;

  logic [15:0] mem [256];
  item_t sb [$];
  int cyc = 0, t_start = 0, checks = 0, errors = 0, spur = 0;
  logic [15:0] ma = '0, mb = '0, last_a = '0, last_b = '0;

  acc_xfer_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .ind(ind),
    .chain_en(chain_en), .done(done), .err(err), .reg_a(reg_a), .reg_b(reg_b),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse; tracks accumulator stability
  always @(negedge clk) begin
    if (!rst) begin
      if ((reg_a !== last_a || reg_b !== last_b) && !done) spur++;
      last_a = reg_a;
      last_b = reg_b;
      if (done) begin
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R8 actual=unexpected done expected=no done");
        end else begin
          item_t it;
          it = sb.pop_front();
          chk({it.tag, " acc A"}, reg_a, it.a);
          chk({it.tag, " acc B"}, reg_b, it.b);
          chk({it.tag, " err"}, err, it.e);
          chk({it.tag, " R7 latency"}, cyc - t_start, it.lat);
          chk({it.tag, " mem"}, mem[it.chk_addr], it.chk_val);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] o, input int ad, input logic i, input logic ch,
                       input logic e, input int lat, input int ca, input logic [15:0] cv,
                       input string tag, input bit wait_end = 1'b1);
    item_t it;
    it.a = ma; it.b = mb; it.e = e; it.lat = lat; it.chk_addr = ca; it.chk_val = cv; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b1; op = o; addr = 15'(ad); ind = i; chain_en = ch;
    @(posedge clk);
    #1 t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    if (wait_end) begin
      wait (sb.size() == 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 16'(k * 3 + 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 acc A", reg_a, 16'h0);
    chk("R9 acc B", reg_b, 16'h0);
    chk("R9 strobes", {done, err, mem_rd, mem_wr}, 4'b0);

    mem[16'h10] = 16'h1234; mem[16'h11] = 16'hBEEF;
    ma = 16'h1234;
    issue(LDA, 16'h10, 0, 0, 0, 2, 16'h10, 16'h1234, "R1 direct load A");
    mb = 16'hBEEF;
    issue(LDB, 16'h11, 0, 0, 0, 2, 16'h11, 16'hBEEF, "R2 direct load B");
    issue(STA, 16'h20, 0, 0, 0, 1, 16'h20, 16'h1234, "R3 direct store A");
    issue(STB, 16'h21, 0, 0, 0, 1, 16'h21, 16'hBEEF, "R3 direct store B");

    // R4: single level, bit 15 of pointer ignored
    mem[16'h30] = 16'h8040; mem[16'h40] = 16'h5A5A; mem[16'h31] = 16'h0041;
    ma = 16'h5A5A;
    issue(LDA, 16'h30, 1, 0, 0, 4, 16'h40, 16'h5A5A, "R4 indirect load A");
    issue(STB, 16'h31, 1, 0, 0, 3, 16'h41, 16'hBEEF, "R4 indirect store B");

    // R5: three-pointer chain
    mem[16'h50] = 16'h8052; mem[16'h52] = 16'h8054; mem[16'h54] = 16'h0060;
    mem[16'h60] = 16'hC3C3;
    mb = 16'hC3C3;
    issue(LDB, 16'h50, 1, 1, 0, 8, 16'h60, 16'hC3C3, "R5 chained load B");
    // R5: chain disabled stops after one pointer even though bit 15 is set
    mem[16'h52] = 16'h8054;
    issue(STA, 16'h50, 1, 0, 0, 3, 16'h52, 16'h5A5A, "R5 chain off store A");

    // R6: eight pointer reads is the limit that still completes
    for (int k = 0; k < 7; k++) mem[16'h80 + k] = 16'h8000 | 16'(16'h81 + k);
    mem[16'h87] = 16'h0070; mem[16'h70] = 16'h7777;
    ma = 16'h7777;
    issue(LDA, 16'h80, 1, 1, 0, 18, 16'h70, 16'h7777, "R6 eight-hop load A");
    // R6: ninth read requested -> abort
    for (int k = 0; k < 8; k++) mem[16'h90 + k] = 16'h8000 | 16'(16'h91 + k);
    mem[16'h98] = 16'h0ABC;
    issue(STB, 16'h90, 1, 1, 1, 16, 16'h98, 16'h0ABC, "R6 chain overflow store B");
    issue(LDB, 16'h90, 1, 1, 1, 16, 16'h97, 16'h8098, "R6 chain overflow load B");

    // R8: start during an operand fetch is ignored
    mem[16'h12] = 16'h0F0F; mem[16'hA0] = 16'h1111; mem[16'hA1] = 16'h1111;
    ma = 16'h0F0F;
    issue(LDA, 16'h12, 0, 0, 0, 2, 16'hA0, 16'h1111, "R8 busy load A", 1'b0);
    start = 1'b1; op = STB; addr = 15'h0A0; ind = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);

    // R8: start in the done cycle is ignored
    mem[16'h13] = 16'h2222;
    mb = 16'h2222;
    issue(LDB, 16'h13, 0, 0, 0, 2, 16'h13, 16'h2222, "R8 done-cycle load B", 1'b0);
    while (!done) @(negedge clk);
    start = 1'b1; op = STA; addr = 15'h0A1; ind = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 ignored store mid-fetch", mem[16'hA0], 16'h1111);
    chk("R8 ignored store in done cycle", mem[16'hA1], 16'h1111);
    chk("R8 no pending item", sb.size(), 0);
    chk("R10 acc changes outside done", spur, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule